// File: doc/BRIEF.md
# GPIO Expander Pin Register File

This block holds the per-pin configuration of a 24-pin general-purpose I/O expander. It is reached over a byte-wide register bus with an address, write data, a write strobe and a read strobe. The pins form three banks of eight, so pin n is bit n%8 of bank n/8. For every pin there is a direction bit, a type bit, a pull bit and an output latch. The latch cannot be written directly: one register sets bits and another clears them. The block drives six per-pin control lines to the pad ring and samples the pad inputs through a two-stage synchronizer.

The type and pull bits mean different things depending on direction. On an output pin, type selects push-pull (0) or open-drain (1), and in open-drain mode the pull bit enables a pull-up. On an input pin, type 1 enables a resistor whose direction is set by the pull bit (1 up, 0 down). With type 0, pull 1 leaves the input floating and pull 0 selects analog mode, which turns the input buffer off.

Pins 0 to 15 are always available. Pins 16 to 19 and pins 20 to 23 are available only while their group enable is high. While a pin is unavailable its pad controls are held low and its state bit reads 0.

Top module: `gpio_pin_regs`

## Requirements
- R1: After reset every register is 0, every pad control output is 0 and rdata_o is 0.
- R2: rdata_o is loaded on the clock edge that samples re_i high and holds its value while re_i is low.
- R3: Direction registers sit at 0x60 (bank 0), 0x61 (bank 1) and 0x63 (bank 2); 0x62 is unmapped. Type registers sit at 0x64-0x66 and pull registers at 0x68-0x6A. All of them read back what was written.
- R4: A write to the set register of bank b (0x6C+b) sets each latch bit written as 1 and leaves bits written as 0 unchanged. A read at 0x6C+b returns that bank's latch.
- R5: A write to the clear register of bank b (0x70+b) clears each latch bit written as 1 and leaves bits written as 0 unchanged. A read at 0x70+b returns that bank's latch.
- R6: On an available pin with direction 1: pad_oe_o=1, pad_out_o=latch, pad_od_o=type, pad_pull_en_o=pad_pull_up_o=type&pull, and pad_ibuf_en_o=1.
- R7: On an available pin with direction 0: pad_oe_o=pad_out_o=pad_od_o=0, pad_pull_en_o=type, pad_pull_up_o=type&pull, and pad_ibuf_en_o=type|pull (0 selects analog mode).
- R8: The state registers at 0x10+b are read-only and return the synchronized pad level ANDed with the pin's input-buffer enable. A pad change is visible to a read whose strobe is sampled on the third rising edge after the change, but not to one sampled on the second.
- R9: Pins 16-19 are available only while alt_en_i[0] is 1, and pins 20-23 only while alt_en_i[1] is 1. An unavailable pin drives every pad control output to 0 and reads 0 in its state bit. Its configuration registers keep their values.
- R10: Reads of any address not listed in R3, R4, R5 or R8 return 0. Writes to those addresses, and writes to the state registers, change nothing.
- R11: Pin n is controlled by bit n%8 of the bank-n/8 registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| alt_en_i | input | 2 | Group enables: bit 0 pins 16-19, bit 1 pins 20-23 |
| pad_in_i | input | 24 | Pad input levels |
| pad_oe_o | output | 24 | Pad driver enable |
| pad_out_o | output | 24 | Pad output value |
| pad_od_o | output | 24 | Open-drain mode |
| pad_pull_en_o | output | 24 | Pull resistor enable |
| pad_pull_up_o | output | 24 | Pull direction, 1 = up |
| pad_ibuf_en_o | output | 24 | Input buffer enable |

## Verification
A register write takes effect on the rising edge that samples we_i, and the pad control outputs follow combinationally. The bench therefore checks the pad outputs at the falling edge that follows the write. Read data appears one edge after the read strobe, so each read is sampled at the next falling edge. For pad inputs, the bench changes a pad at a falling edge and issues one read at the following falling edge, which must still return the old level. The next read, issued one cycle later, must return the new level. Sweeps over every address and over many direction/type/pull/latch patterns are compared against a register model held in the bench.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;
  typedef enum logic [2:0] {
    RK_NONE, RK_STATE, RK_DIR, RK_TYPE, RK_PULL, RK_SET, RK_CLR
  } reg_kind_e;

  localparam logic [7:0] BASE_STATE = 8'h10;
  localparam logic [7:0] BASE_DIR   = 8'h60;
  localparam logic [7:0] BASE_TYPE  = 8'h64;
  localparam logic [7:0] BASE_PULL  = 8'h68;
  localparam logic [7:0] BASE_SET   = 8'h6C;
  localparam logic [7:0] BASE_CLR   = 8'h70;
  localparam int WIN_BITS = 2;
  // hole inside the direction window
  localparam int DIR_GAP = 2;

  typedef struct packed {
    logic oe;
    logic out;
    logic od;
    logic pull_en;
    logic pull_up;
    logic ibuf_en;
  } pad_ctl_t;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_pin_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int BIDX_W    = 2
) (
  input  logic [7:0]        addr_i,
  output reg_kind_e         kind_o,
  output logic [BIDX_W-1:0] bank_o
);
  logic [7:0] wbase;
  int         ofs;

  assign wbase = {addr_i[7:WIN_BITS], {WIN_BITS{1'b0}}};
  assign ofs   = int'(addr_i[WIN_BITS-1:0]);

  always_comb begin
    kind_o = RK_NONE;
    bank_o = '0;
    if (wbase == BASE_DIR) begin
      if (ofs < DIR_GAP) begin
        kind_o = RK_DIR;
        bank_o = BIDX_W'(ofs);
      end else if (ofs > DIR_GAP && (ofs - 1) < NUM_BANKS) begin
        kind_o = RK_DIR;
        bank_o = BIDX_W'(ofs - 1);
      end
    end else if (ofs < NUM_BANKS) begin
      bank_o = BIDX_W'(ofs);
      case (wbase)
        BASE_STATE: kind_o = RK_STATE;
        BASE_TYPE:  kind_o = RK_TYPE;
        BASE_PULL:  kind_o = RK_PULL;
        BASE_SET:   kind_o = RK_SET;
        BASE_CLR:   kind_o = RK_CLR;
        default:    kind_o = RK_NONE;
      endcase
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pin_pkg::*;
#(
  parameter int BANK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  reg_kind_e         kind_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [BANK_W-1:0] dir_o,
  output logic [BANK_W-1:0] type_o,
  output logic [BANK_W-1:0] pull_o,
  output logic [BANK_W-1:0] lat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o  <= '0;
      type_o <= '0;
      pull_o <= '0;
      lat_o  <= '0;
    end else if (wr_i) begin
      case (kind_i)
        RK_DIR:  dir_o  <= wdata_i;
        RK_TYPE: type_o <= wdata_i;
        RK_PULL: pull_o <= wdata_i;
        RK_SET:  lat_o  <= lat_o | wdata_i;
        RK_CLR:  lat_o  <= lat_o & ~wdata_i;
        default: ;
      endcase
    end
  end

  assert_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && kind_i == RK_SET) |=>
      ((lat_o & $past(wdata_i)) == $past(wdata_i)) &&
      ((lat_o & ~$past(wdata_i)) == ($past(lat_o) & ~$past(wdata_i))));

  assert_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && kind_i == RK_CLR) |=>
      ((lat_o & $past(wdata_i)) == '0) &&
      ((lat_o & ~$past(wdata_i)) == ($past(lat_o) & ~$past(wdata_i))));

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(dir_o) && $stable(type_o) && $stable(pull_o) && $stable(lat_o));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_pad_map.sv
module gpio_pad_map
  import gpio_pin_pkg::*;
(
  input  logic     usable_i,
  input  logic     dir_i,
  input  logic     type_i,
  input  logic     pull_i,
  input  logic     lat_i,
  output pad_ctl_t ctl_o
);
  pad_ctl_t c;

  always_comb begin
    c.oe      = dir_i;
    c.out     = dir_i & lat_i;
    c.od      = dir_i & type_i;
    // output: pull only as open-drain pull-up; input: type enables the resistor
    c.pull_en = dir_i ? (type_i & pull_i) : type_i;
    c.pull_up = type_i & pull_i;
    // input with type 0 and pull 0 is analog
    c.ibuf_en = dir_i | type_i | pull_i;
    ctl_o     = usable_i ? c : '0;
  end
endmodule

// File: rtl/gpio_pin_regs.sv
module gpio_pin_regs
  import gpio_pin_pkg::*;
#(
  parameter int BANK_W      = 8,
  parameter int NUM_BANKS   = 3,
  parameter int ALWAYS_PINS = 16,
  parameter int ALT_GRP_W   = 4,
  localparam int NUM_PINS   = BANK_W * NUM_BANKS,
  localparam int NUM_ALT    = (NUM_PINS - ALWAYS_PINS) / ALT_GRP_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [7:0]          addr_i,
  input  logic [BANK_W-1:0]   wdata_i,
  input  logic                we_i,
  input  logic                re_i,
  output logic [BANK_W-1:0]   rdata_o,
  input  logic [NUM_ALT-1:0]  alt_en_i,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_od_o,
  output logic [NUM_PINS-1:0] pad_pull_en_o,
  output logic [NUM_PINS-1:0] pad_pull_up_o,
  output logic [NUM_PINS-1:0] pad_ibuf_en_o
);
  localparam int BIDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  reg_kind_e   kind;
  logic [BIDX_W-1:0] bank;

  logic [NUM_BANKS-1:0][BANK_W-1:0] dir_b, type_b, pull_b, lat_b, state_b;
  logic [NUM_PINS-1:0] dir_f, type_f, pull_f, lat_f, sync_f, usable;
  logic [BANK_W-1:0]   rd_mux;
  pad_ctl_t            ctl [NUM_PINS];

  gpio_addr_dec #(.NUM_BANKS(NUM_BANKS), .BIDX_W(BIDX_W)) u_dec (
    .addr_i (addr_i),
    .kind_o (kind),
    .bank_o (bank)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_bank #(.BANK_W(BANK_W)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (we_i && (kind != RK_NONE) && (bank == BIDX_W'(b))),
      .kind_i  (kind),
      .wdata_i (wdata_i),
      .dir_o   (dir_b[b]),
      .type_o  (type_b[b]),
      .pull_o  (pull_b[b]),
      .lat_o   (lat_b[b])
    );
  end

  assign dir_f  = dir_b;
  assign type_f = type_b;
  assign pull_f = pull_b;
  assign lat_f  = lat_b;

  gpio_in_sync #(.W(NUM_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (sync_f)
  );

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    if (n < ALWAYS_PINS) begin : g_fixed
      assign usable[n] = 1'b1;
    end else begin : g_alt
      assign usable[n] = alt_en_i[(n - ALWAYS_PINS) / ALT_GRP_W];
    end

    gpio_pad_map u_map (
      .usable_i (usable[n]),
      .dir_i    (dir_f[n]),
      .type_i   (type_f[n]),
      .pull_i   (pull_f[n]),
      .lat_i    (lat_f[n]),
      .ctl_o    (ctl[n])
    );

    assign pad_oe_o[n]      = ctl[n].oe;
    assign pad_out_o[n]     = ctl[n].out;
    assign pad_od_o[n]      = ctl[n].od;
    assign pad_pull_en_o[n] = ctl[n].pull_en;
    assign pad_pull_up_o[n] = ctl[n].pull_up;
    assign pad_ibuf_en_o[n] = ctl[n].ibuf_en;
  end

  // ibuf enable already carries the availability mask
  assign state_b = sync_f & pad_ibuf_en_o;

  always_comb begin
    case (kind)
      RK_STATE:        rd_mux = state_b[bank];
      RK_DIR:          rd_mux = dir_b[bank];
      RK_TYPE:         rd_mux = type_b[bank];
      RK_PULL:         rd_mux = pull_b[bank];
      RK_SET, RK_CLR:  rd_mux = lat_b[bank];
      default:         rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd_mux;
  end

  assert_rdata_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));

  assert_unmapped_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && kind == RK_NONE) |=> rdata_o == '0);

  assert_ignored_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (kind == RK_NONE || kind == RK_STATE)) |=>
      $stable(dir_b) && $stable(type_b) && $stable(pull_b) && $stable(lat_b));

  assert_unusable_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o | pad_out_o | pad_od_o | pad_pull_en_o | pad_pull_up_o | pad_ibuf_en_o)
      & ~usable) == '0);
endmodule

// File: tb/gpio_pin_regs_test.sv
module gpio_pin_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0, wdata = '0, rdata;
  logic        we = 1'b0, re = 1'b0;
  logic [1:0]  alt_en = '0;
  logic [23:0] pad_in = '0;
  logic [23:0] oe, outv, od, pen, pup, ibuf;
  int checks = 0, failures = 0;

  logic [7:0] m_dir [3], m_type [3], m_pull [3], m_lat [3];

  always #5 clk = ~clk;

  gpio_pin_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we), .re_i(re),
    .rdata_o(rdata), .alt_en_i(alt_en), .pad_in_i(pad_in),
    .pad_oe_o(oe), .pad_out_o(outv), .pad_od_o(od), .pad_pull_en_o(pen),
    .pad_pull_up_o(pup), .pad_ibuf_en_o(ibuf)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic bit usable_m(int n);
    if (n < 16) return 1'b1;
    if (n < 20) return alt_en[0];
    return alt_en[1];
  endfunction

  function automatic logic [7:0] dir_addr(int b);
    return (b < 2) ? 8'(8'h60 + b) : 8'h63;
  endfunction

  function automatic logic [7:0] exp_read(int a);
    logic [7:0] v;
    v = '0;
    if (a >= 'h10 && a <= 'h12) begin
      for (int i = 0; i < 8; i++) begin
        int n;
        int b;
        b = a - 'h10;
        n = b * 8 + i;
        v[i] = usable_m(n) & (m_dir[b][i] | m_type[b][i] | m_pull[b][i]) & pad_in[n];
      end
    end else if (a == 'h60 || a == 'h61) v = m_dir[a - 'h60];
    else if (a == 'h63) v = m_dir[2];
    else if (a >= 'h64 && a <= 'h66) v = m_type[a - 'h64];
    else if (a >= 'h68 && a <= 'h6A) v = m_pull[a - 'h68];
    else if (a >= 'h6C && a <= 'h6E) v = m_lat[a - 'h6C];
    else if (a >= 'h70 && a <= 'h72) v = m_lat[a - 'h70];
    return v;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    int ai;
    ai = int'(a);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    if (ai == 'h60 || ai == 'h61) m_dir[ai - 'h60] = d;
    else if (ai == 'h63) m_dir[2] = d;
    else if (ai >= 'h64 && ai <= 'h66) m_type[ai - 'h64] = d;
    else if (ai >= 'h68 && ai <= 'h6A) m_pull[ai - 'h68] = d;
    else if (ai >= 'h6C && ai <= 'h6E) m_lat[ai - 'h6C] = m_lat[ai - 'h6C] | d;
    else if (ai >= 'h70 && ai <= 'h72) m_lat[ai - 'h70] = m_lat[ai - 'h70] & ~d;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    v = rdata;
  endtask

  task automatic read_all(input string tag);
    logic [7:0] v;
    for (int a = 0; a < 256; a++) begin
      rd(8'(a), v);
      chk(tag, {24'd0, v}, {24'd0, exp_read(a)});
    end
  endtask

  task automatic check_pads(input string tag);
    logic [23:0] e_oe, e_out, e_od, e_pen, e_pup, e_ib;
    for (int n = 0; n < 24; n++) begin
      bit u, d, t, p, l;
      u = usable_m(n);
      d = m_dir[n/8][n%8]; t = m_type[n/8][n%8];
      p = m_pull[n/8][n%8]; l = m_lat[n/8][n%8];
      e_oe[n]  = u & d;
      e_out[n] = u & d & l;
      e_od[n]  = u & d & t;
      e_pen[n] = u & (d ? (t & p) : t);
      e_pup[n] = u & t & p;
      e_ib[n]  = u & (d | t | p);
    end
    chk({tag, " oe"}, {8'd0, oe}, {8'd0, e_oe});
    chk({tag, " out"}, {8'd0, outv}, {8'd0, e_out});
    chk({tag, " od"}, {8'd0, od}, {8'd0, e_od});
    chk({tag, " pull_en"}, {8'd0, pen}, {8'd0, e_pen});
    chk({tag, " pull_up"}, {8'd0, pup}, {8'd0, e_pup});
    chk({tag, " ibuf"}, {8'd0, ibuf}, {8'd0, e_ib});
  endtask

  task automatic clear_all;
    for (int b = 0; b < 3; b++) begin
      wr(dir_addr(b), 8'h00);
      wr(8'(8'h64 + b), 8'h00);
      wr(8'(8'h68 + b), 8'h00);
      wr(8'(8'h70 + b), 8'hFF);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
    $finish;
  end

  initial begin
    logic [7:0] v;
    for (int b = 0; b < 3; b++) begin
      m_dir[b] = '0; m_type[b] = '0; m_pull[b] = '0; m_lat[b] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    chk("R1 rdata", {24'd0, rdata}, 32'd0);
    alt_en = 2'b11;
    check_pads("R1");
    rd(8'h60, v); chk("R1 dir0", {24'd0, v}, 32'd0);
    rd(8'h6E, v); chk("R1 lat2", {24'd0, v}, 32'd0);

    // R3 readback of every address after distinct writes
    for (int b = 0; b < 3; b++) begin
      wr(dir_addr(b), 8'(8'h1B * (b + 1)));
      wr(8'(8'h64 + b), 8'(8'h2D * (b + 2)));
      wr(8'(8'h68 + b), 8'(8'h47 * (b + 1) + 1));
    end
    read_all("R3");

    // R11 one-hot pin placement
    clear_all();
    for (int n = 0; n < 24; n++) begin
      for (int b = 0; b < 3; b++) wr(dir_addr(b), (b == n / 8) ? 8'(1 << (n % 8)) : 8'h00);
      chk("R11 oe", {8'd0, oe}, 32'(1 << n));
    end

    // R6/R7 pattern sweep
    for (int k = 0; k < 40; k++) begin
      for (int b = 0; b < 3; b++) begin
        wr(dir_addr(b), 8'(k * 37 + b * 11));
        wr(8'(8'h64 + b), 8'(k * 91 + b * 29 + 3));
        wr(8'(8'h68 + b), 8'(k * 53 + b * 7 + 5));
        wr(8'(8'h6C + b), 8'(k * 19 + b));
        wr(8'(8'h70 + b), 8'(k * 23 + b * 3));
      end
      check_pads("R6/R7");
    end

    // R4/R5 set and clear
    clear_all();
    wr(8'h61, 8'hFF);
    wr(8'h6D, 8'hA5); rd(8'h6D, v); chk("R4 set", {24'd0, v}, 32'hA5);
    wr(8'h6D, 8'h0F); rd(8'h6D, v); chk("R4 set keep", {24'd0, v}, 32'hAF);
    chk("R4 pad_out", {8'd0, outv}, 32'h00AF00);
    wr(8'h71, 8'h81); rd(8'h71, v); chk("R5 clear", {24'd0, v}, 32'h2E);
    wr(8'h71, 8'h00); rd(8'h6D, v); chk("R5 clear zero", {24'd0, v}, 32'h2E);
    chk("R5 pad_out", {8'd0, outv}, 32'h002E00);

    // R2 hold while re_i low
    rd(8'h64, v);
    @(negedge clk) addr = 8'h6D;
    repeat (3) @(negedge clk);
    chk("R2 hold", {24'd0, rdata}, {24'd0, exp_read('h64)});

    // R8 synchronizer latency and input modes
    wr(8'h60, 8'h00); wr(8'h64, 8'hFF); wr(8'h68, 8'hFF);
    repeat (3) @(negedge clk);
    pad_in[7:0] = 8'h3C;
    rd(8'h10, v); chk("R8 early", {24'd0, v}, 32'h00);
    rd(8'h10, v); chk("R8 synced", {24'd0, v}, 32'h3C);
    wr(8'h64, 8'h00); wr(8'h68, 8'h00);
    rd(8'h10, v); chk("R8 analog", {24'd0, v}, 32'h00);
    wr(8'h68, 8'hF0);
    rd(8'h10, v); chk("R8 floating", {24'd0, v}, 32'h30);
    wr(8'h10, 8'hFF);
    rd(8'h10, v); chk("R8 read-only", {24'd0, v}, 32'h30);
    check_pads("R8");

    // R9 group enables
    pad_in = 24'hFFFFFF;
    wr(8'h63, 8'h0F); wr(8'h66, 8'hFF); wr(8'h6A, 8'h33);
    for (int ae = 0; ae < 4; ae++) begin
      @(negedge clk) alt_en = 2'(ae);
      repeat (3) @(negedge clk);
      rd(8'h12, v); chk("R9 state", {24'd0, v}, {24'd0, exp_read('h12)});
      rd(8'h66, v); chk("R9 retained", {24'd0, v}, 32'hFF);
      check_pads("R9");
    end

    // R10 unmapped writes ignored, all reads match model
    for (int a = 0; a < 256; a++) begin
      bit mapped;
      mapped = (a == 'h60 || a == 'h61 || a == 'h63 ||
                (a >= 'h64 && a <= 'h66) || (a >= 'h68 && a <= 'h6A) ||
                (a >= 'h6C && a <= 'h6E) || (a >= 'h70 && a <= 'h72));
      if (!mapped) wr(8'(a), 8'hFF);
    end
    read_all("R10");
    check_pads("R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule